// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is one DMA channel that moves bytes between memory and a single peripheral. It holds two buffer slots. Each slot has a current address and a remaining byte count. The channel drains the slots in strict alternation, starting with slot 0. While one slot is running, software can refill the other, so the stream continues without a gap.

For each byte the channel first runs a request/acknowledge handshake with the peripheral, then makes one access on a simple memory request interface. After that access it steps the slot's address up by one and its count down by one. Software drives the channel through a small word-addressed register file, which holds:
- the control bits,
- the interrupt flags,
- the peripheral port select,
- the live channel state,
- the two slot register pairs.

A single interrupt line combines the stall, reload-ready and error conditions that software has enabled.

The transfer direction is fixed by a parameter. With the default, the channel reads memory and feeds the peripheral.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset, every register reads 0, the state field reads idle (0), and `per_req`, `mem_req` and `irq` are low.
- R2: Registers are decoded at these byte offsets: control 0x00, interrupt 0x04, port select 0x08, state 0x0C, slot-0 count 0x20, slot-0 address 0x24, slot-1 count 0x30, slot-1 address 0x34.
  - Control keeps only bits 0 (stall irq enable), 1 (reload irq enable), 3 (error irq enable), 4 (run) and 6 (error ends slot). All other control bits read back as 0.
  - The port select keeps bits [3:0] and drives `per_port`.
  - Counts are 16 bits wide.
- R3: Each byte is one peripheral handshake followed by one memory access.
  - `per_req` stays high until `per_ack` is seen, and only then is `mem_req` raised.
  - `mem_req` stays high until `mem_ack` or `mem_err`.
  - `per_req` and `mem_req` are never high together.
- R4: `mem_addr` is the running slot's current address. Each finished access adds 1 to that address and subtracts 1 from the slot's count. Both changes can be read back.
- R5: The state register reports state in bits [5:4]: 0 idle, 1 stall, 2 on, 3 next.
  - With run set and the active slot loaded, the state is next (3) if the other slot is also loaded, otherwise on (2).
  - The interrupt register shows bit 1 (reload ready) while the state is on.
  - Slots run in alternation from slot 0. When a slot empties while the other is loaded, the channel moves on to the other slot.
- R6: When the slot due next is not loaded and run is set, the state is stall (1). The interrupt register then shows bit 0.
- R7: `irq` is the OR of interrupt-register bits 0, 1 and 3, each ANDed with the control bit at the same position.
- R8: `mem_err` during an access sets interrupt bit 3, and the byte still counts as moved. Any write to offset 0x04 clears bit 3.
- R9: With control bit 6 set, an access that ends in `mem_err` also ends the running slot. The slot is unloaded and the other slot becomes due.
- R10: Clearing run while bytes are moving lets the byte in flight finish its memory access. The channel then goes idle, drops both loaded marks and points back at slot 0. Clearing run in stall returns to idle.
- R11: A loaded slot with count 0 completes without any handshake, and the other slot becomes due.
- R12: Writing a slot's count register marks that slot loaded. Loading the due slot while in stall resumes transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| per_port | output | 4 | Selected peripheral port |
| per_req | output | 1 | Peripheral byte request |
| per_ack | input | 1 | Peripheral byte acknowledge |
| mem_req | output | 1 | Memory access request |
| mem_write | output | 1 | Access is a memory write (fixed by direction) |
| mem_addr | output | AW | Memory byte address |
| mem_ack | input | 1 | Memory access done |
| mem_err | input | 1 | Memory access failed |
| irq | output | 1 | Combined enabled interrupt |

## Verification
A register write takes effect at the clock edge on which it is sampled, and read data follows `reg_addr` with no delay. The bench therefore reads a register half a cycle after the write has been applied. Setting the run bit changes the state field one edge later, so the bench waits one extra cycle before it checks the state after enabling.

The completion of a slot depends on how fast the bench's responders answer, so the bench polls the state field for the expected value up to a bounded limit. It checks byte counts and addresses at the first sample where that state appears. At that sample, the responder counters and the design's state have both been updated by the same edge.

// File: rtl/pp_dma_chan.sv
module pp_dma_chan #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter bit TO_PERIPH = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [5:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic [3:0]    per_port,
  output logic          per_req,
  input  logic          per_ack,
  output logic          mem_req,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          irq
);
  localparam logic [6:0] CTRL_MASK = 7'h5B;
  localparam logic [1:0] ST_IDLE = 2'd0, ST_STALL = 2'd1, ST_ON = 2'd2, ST_NEXT = 2'd3;

  typedef enum logic [1:0] {PH_IDLE, PH_PER, PH_MEM} phase_t;

  logic [6:0]    ctrl;
  logic [3:0]    port;
  logic [AW-1:0] base [2];
  logic [CW-1:0] cnt  [2];
  logic [1:0]    loaded;
  logic          cur, run, err_flag;
  phase_t        phase;
  logic [1:0]    state;
  logic [3:0]    istat;

  wire ena = ctrl[4];

  always_comb begin
    if (!run)                state = ST_IDLE;
    else if (!loaded[cur])   state = ST_STALL;
    else if (loaded[~cur])   state = ST_NEXT;
    else                     state = ST_ON;
  end

  assign istat     = {err_flag, 1'b0, state == ST_ON, state == ST_STALL};
  assign irq       = |(istat & {ctrl[3], 1'b0, ctrl[1], ctrl[0]});
  assign per_req   = phase == PH_PER;
  assign mem_req   = phase == PH_MEM;
  assign mem_addr  = base[cur];
  assign mem_write = !TO_PERIPH;
  assign per_port  = port;

  always_comb begin
    case (reg_addr)
      6'h00:   reg_rdata = {25'd0, ctrl};
      6'h04:   reg_rdata = {28'd0, istat};
      6'h08:   reg_rdata = {28'd0, port};
      6'h0C:   reg_rdata = {26'd0, state, 4'd0};
      6'h20:   reg_rdata = 32'(cnt[0]);
      6'h24:   reg_rdata = 32'(base[0]);
      6'h30:   reg_rdata = 32'(cnt[1]);
      6'h34:   reg_rdata = 32'(base[1]);
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; port <= '0; loaded <= '0; cur <= 1'b0; run <= 1'b0;
      err_flag <= 1'b0; phase <= PH_IDLE;
      base[0] <= '0; base[1] <= '0; cnt[0] <= '0; cnt[1] <= '0;
    end else begin
      if (run) begin
        case (phase)
          PH_IDLE: begin
            if (!ena) begin
              run <= 1'b0; loaded <= '0; cur <= 1'b0;
            end else if (loaded[cur]) begin
              if (cnt[cur] == '0) begin
                loaded[cur] <= 1'b0; cur <= ~cur;
              end else phase <= PH_PER;
            end
          end
          PH_PER: if (per_ack) phase <= PH_MEM;
          default: if (mem_ack || mem_err) begin
            phase     <= PH_IDLE;
            base[cur] <= base[cur] + AW'(1);
            cnt[cur]  <= cnt[cur] - CW'(1);
            if (mem_err) err_flag <= 1'b1;
            if (cnt[cur] == CW'(1) || (mem_err && ctrl[6])) begin
              loaded[cur] <= 1'b0; cur <= ~cur;
            end
          end
        endcase
      end else if (ena) run <= 1'b1;

      if (reg_we) begin
        case (reg_addr)
          6'h00: ctrl <= reg_wdata[6:0] & CTRL_MASK;
          6'h04: err_flag <= 1'b0;
          6'h08: port <= reg_wdata[3:0];
          6'h20: begin cnt[0] <= reg_wdata[CW-1:0]; loaded[0] <= 1'b1; end
          6'h24: base[0] <= reg_wdata[AW-1:0];
          6'h30: begin cnt[1] <= reg_wdata[CW-1:0]; loaded[1] <= 1'b1; end
          6'h34: base[1] <= reg_wdata[AW-1:0];
          default: ;
        endcase
      end
    end
  end

  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_req && mem_req));
  a_r3_per_hold: assert property (@(posedge clk) disable iff (!rst_n)
    per_req && !per_ack |=> per_req);
  a_r3_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !mem_err |=> mem_req);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !per_req && !mem_req);
  a_r8_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(mem_req && mem_err));
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && loaded[~cur] == 1'b0 && cnt[cur] != CW'(1) |=> mem_addr == $past(mem_addr) + AW'(1));
endmodule

// File: tb/pp_dma_chan_test.sv
module pp_dma_chan_test;
  localparam int PERIOD = 10;
  localparam int AW = 32;
  localparam int NV = 6;
  localparam logic [69:0] VEC [NV] = '{
    {6'h08, 32'h0000_003A, 32'h0000_000A},
    {6'h24, 32'h0000_1000, 32'h0000_1000},
    {6'h34, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {6'h00, 32'hFFFF_FFAF, 32'h0000_000B},
    {6'h00, 32'h0000_0040, 32'h0000_0040},
    {6'h00, 32'h0000_0000, 32'h0000_0000}
  };

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0] per_port;
  logic per_req, per_ack = 0, mem_req, mem_write, mem_ack = 0, mem_err = 0, irq;
  logic [AW-1:0] mem_addr;

  int checks = 0, fails = 0;
  int n_acc = 0, n_per = 0;
  logic [AW-1:0] last_addr = '0;
  logic inject = 0, overlap = 0;
  logic [31:0] v;
  int b0, p0;

  pp_dma_chan uut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_port(per_port),
    .per_req(per_req), .per_ack(per_ack), .mem_req(mem_req), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq));

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    per_ack <= per_req && !per_ack;
    mem_ack <= mem_req && !mem_ack && !mem_err && !inject;
    mem_err <= mem_req && !mem_ack && !mem_err && inject;
    if (mem_req && !mem_ack && !mem_err && inject) inject <= 1'b0;
    if (per_req && per_ack) n_per <= n_per + 1;
    if (mem_req && mem_ack) begin n_acc <= n_acc + 1; last_addr <= mem_addr; end
  end

  always @(negedge clk) if (per_req && mem_req) overlap <= 1'b1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_stat(string req, logic [31:0] exp);
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); rd(6'h0C, s);
      if (s == exp) return;
    end
    chk(req, s, exp);
  endtask

  task automatic tick(); @(negedge clk); endtask

  initial begin
    #(PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    foreach (VEC[i]) begin rd(VEC[i][69:64], v); chk("R1 reset reg", v, 0); end
    rd(6'h0C, v); chk("R1 reset state", v, 0);
    chk("R1 reset outputs", {29'd0, per_req, mem_req, irq}, 0);

    // R2 register table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][69:64], VEC[i][63:32]);
      rd(VEC[i][69:64], v);
      chk("R2 readback", v, VEC[i][31:0]);
    end
    chk("R2 per_port", {28'd0, per_port}, 32'hA);
    wr(6'h20, 32'h0001_0003); rd(6'h20, v); chk("R2 count width", v, 3);

    // R5 R6 R4 R7 ping-pong
    wr(6'h24, 32'h100); wr(6'h34, 32'h200); wr(6'h30, 2);
    wr(6'h00, 32'h13); tick();
    rd(6'h0C, v); chk("R5 next state", v, 32'h30);
    wait_stat("R5 on after slot0", 32'h20);
    chk("R4 bytes slot0", n_acc, 3);
    chk("R4 last addr slot0", last_addr, 32'h102);
    rd(6'h04, v); chk("R5 reload flag", v, 32'h2);
    chk("R7 irq reload", {31'd0, irq}, 1);
    wait_stat("R6 stall", 32'h10);
    chk("R5 bytes total", n_acc, 5);
    chk("R5 last addr slot1", last_addr, 32'h201);
    rd(6'h04, v); chk("R6 stall flag", v, 32'h1);
    rd(6'h24, v); chk("R4 base0 advanced", v, 32'h103);
    rd(6'h30, v); chk("R4 count1 drained", v, 0);

    // R12 resume from stall
    wr(6'h24, 32'h300); wr(6'h20, 1);
    wait_stat("R12 resume", 32'h10);
    chk("R12 bytes", n_acc, 6);
    chk("R12 addr", last_addr, 32'h300);

    // R7 masking
    wr(6'h00, 32'h12); chk("R7 irq masked", {31'd0, irq}, 0);

    // R8 error
    wr(6'h00, 32'h18); wr(6'h34, 32'h400); inject = 1; wr(6'h30, 2);
    tick(); tick();
    wait_stat("R8 stall", 32'h10);
    rd(6'h04, v); chk("R8 err flag", v, 32'h9);
    chk("R8 irq err", {31'd0, irq}, 1);
    rd(6'h34, v); chk("R8 byte counted", v, 32'h402);
    wr(6'h04, 0); rd(6'h04, v); chk("R8 clear", v, 32'h1);
    chk("R8 irq cleared", {31'd0, irq}, 0);

    // R9 error ends slot
    wr(6'h00, 32'h58); wr(6'h24, 32'h500); inject = 1; wr(6'h20, 4);
    tick(); tick();
    wait_stat("R9 stall", 32'h10);
    rd(6'h24, v); chk("R9 base0", v, 32'h501);
    rd(6'h20, v); chk("R9 count0", v, 3);

    // R11 zero count
    p0 = n_per;
    wr(6'h30, 0); repeat (4) tick();
    rd(6'h0C, v); chk("R11 state", v, 32'h10);
    chk("R11 no handshake", n_per, p0);

    // R10 disable mid-transfer
    wr(6'h00, 32'h10); wr(6'h24, 32'h600); wr(6'h20, 5);
    for (int i = 0; i < 200 && !mem_req; i++) tick();
    b0 = n_acc;
    wr(6'h00, 0);
    wait_stat("R10 idle", 0);
    p0 = n_per;
    chk("R10 byte finished", n_acc, b0 + 1);
    rd(6'h20, v); chk("R10 count0", v, 4);
    repeat (10) tick();
    chk("R10 no new request", n_per, p0);
    wr(6'h30, 1); wr(6'h00, 32'h10); tick();
    rd(6'h0C, v); chk("R10 pointer back to slot0", v, 32'h10);
    wr(6'h00, 0); tick();
    rd(6'h0C, v); chk("R10 stall to idle", v, 0);

    chk("R3 no overlap", {31'd0, overlap}, 0);
    chk("R3 direction", {31'd0, mem_write}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule